// File: doc/BRIEF.md
# PLL Power-Up and Lock Sequencer

This block owns the control words of a small group of on-chip PLLs and runs the register sequences that turn them on, turn them off and give them new divider settings. A command names one PLL and an operation. The block then performs a fixed series of single-cycle register writes. It watches that PLL's lock bits in a shared lock-status word and pulses a slip-clear bit until lock arrives, or until a programmable wait limit runs out. For every PLL it also reports the output frequency implied by the current register contents and the reference rate.

Commands use a valid/ready handshake. `busy` is high from the cycle after acceptance until the cycle after the last register write. Each control word is a 32-bit output, and the analog PLL reads it directly. The lock-status word comes in from the PLLs, and the slip-clear pulses go back to them on a separate 32-bit output.

The state machine has these states:
- `S_IDLE`
- `S_DIS_BYP`, which sets bypass
- `S_DIS_OFF`, which clears power and output enable
- `S_PROG`, which writes the dividers
- `S_EN_PWR`, which sets power
- `S_RST_LO`, `S_RST_HI` and `S_RST_REL`, which frame the reset pulse
- `S_LOCK_WAIT`
- `S_EN_RUN`, which clears bypass and sets output enable
- `S_ERR_BYP`, which forces bypass after a timeout

Transitions:
- `S_IDLE` goes to `S_DIS_BYP` for disable or reprogram, and to `S_EN_PWR` for enable.
- `S_DIS_BYP` goes to `S_DIS_OFF`.
- `S_DIS_OFF` goes to `S_PROG` when reprogramming, and to `S_IDLE` otherwise.
- `S_PROG` goes to `S_EN_PWR`.
- `S_EN_PWR` goes to `S_RST_LO`, which goes to `S_RST_HI`.
- `S_RST_HI` stays for `RST_HOLD` cycles, then goes to `S_RST_REL`.
- `S_RST_REL` goes to `S_LOCK_WAIT`.
- `S_LOCK_WAIT` goes to `S_EN_RUN` on lock, and to `S_ERR_BYP` when the limit is reached.
- `S_EN_RUN` and `S_ERR_BYP` both return to `S_IDLE`.

Top module: `pll_seq`

## Requirements
- R1: After reset every control word is zero, `busy`, `err` and `clr_slip` are low, `cmd_ready` is high, and every reported rate is 0.
- R2: Control word layout:

  | Bits | Field |
  |------|-------|
  | 3:0 | input divider minus one |
  | 9:4 | feedback multiplier minus one |
  | 13:10 | output divider minus one |
  | 19:14 | bandwidth trim |
  | 20 | PLL reset |
  | 21 | power |
  | 22 | internal feedback |
  | 23 | bypass |
  | 24 | test |
  | 25 | output enable |
  | 26 | test enable |

  The block never changes bits 22, 24, 26 or 31:27.
- R3: Operation codes are 0 = enable, 1 = disable, 2 = reprogram and 3 = none. An enable command whose PLL already has power and output enable set, with reset clear, is accepted but writes nothing and leaves `busy` low.
- R4: The enable sequence writes in this order:
  1. Set power.
  2. Clear reset.
  3. Set reset and hold it for `RST_HOLD` (default 2) cycles.
  4. Clear reset.
  5. Wait for lock.
  6. Clear bypass and set output enable in one write.

  With K unlocked cycles, `busy` is high for 7+K cycles.
- R5: A PLL is locked when all bits of its lock field are 1. The fields are PLL0 at bits 1:0, PLL1 at bit 8 and PLL2 at bit 16. During each unlocked wait cycle, exactly one `clr_slip` bit is high: the bit at that field's base position plus 2 (bit 2, 10 or 18). `clr_slip` is zero at all other times.
- R6: The disable sequence first sets bypass. One cycle later it clears power and output enable. `busy` is high for 2 cycles.
- R7: Reprogram runs the disable sequence, then writes r−1, f−1 and od−1 into their fields and f−1 into the bandwidth trim, then runs the enable sequence. With K unlocked cycles, `busy` is high for 10+K cycles.
- R8: The rate output of each PLL is:
  - `rate_in` when bypass is set;
  - otherwise 0 when power is clear;
  - otherwise floor(`rate_in`·f/(r·od)), where each field is decoded as stored value plus one.
- R9: If the lock wait sees `lock_limit`+1 unlocked cycles, the block sets bypass in one write, leaves output enable clear, and raises `err`.
- R10: `cmd_ready` is high only when `busy` is low. `busy` rises only after an accepted command. `err` clears when the next command is accepted.
- R11: A command with operation code 3, or with a PLL index of `NUM_PLL` or above, is accepted and changes no control word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_op | input | 2 | Operation code |
| cmd_sel | input | SEL_W | PLL index |
| cmd_r | input | 5 | Input divider, 1 to 16 |
| cmd_f | input | 7 | Feedback multiplier, 1 to 64 |
| cmd_od | input | 5 | Output divider, 1 to 16 |
| lock_status | input | 32 | Shared lock-status word |
| lock_limit | input | TMO_W | Lock wait limit |
| rate_in | input | RATE_W | Reference rate |
| clr_slip | output | 32 | Slip-clear pulses |
| ctrl_regs | output | NUM_PLL*32 | Control words, with PLL0 in the low bits |
| rate_out | output | NUM_PLL*(RATE_W+6) | Reported output rates |
| busy | output | 1 | Sequence in progress |
| err | output | 1 | Last lock wait timed out |

## Verification
The bench builds the block with three PLLs, a 16-bit reference rate and an 8-bit wait limit. The narrow rate lets the bench compute every expected frequency exactly while it reprograms through all 256 input/output divider pairs. Each pair gets a varying multiplier, PLL index and lock delay. The short limit lets the bench reach the timeout in a handful of cycles and then check the enable, disable, no-op and ignored-command paths against the same PLLs.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
    localparam int CTRL_W = 32;
    localparam int R_LSB  = 0;
    localparam int R_W    = 4;
    localparam int F_LSB  = 4;
    localparam int F_W    = 6;
    localparam int OD_LSB = 10;
    localparam int OD_W   = 4;
    localparam int BW_LSB = 14;
    localparam int BW_W   = 6;
    localparam int B_RST  = 20;
    localparam int B_PWR  = 21;
    localparam int B_BYP  = 23;
    localparam int B_EN   = 25;

    typedef enum logic [1:0] {
        OP_ENABLE  = 2'd0,
        OP_DISABLE = 2'd1,
        OP_REPROG  = 2'd2,
        OP_NONE    = 2'd3
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE, S_DIS_BYP, S_DIS_OFF, S_PROG, S_EN_PWR, S_RST_LO,
        S_RST_HI, S_RST_REL, S_LOCK_WAIT, S_EN_RUN, S_ERR_BYP
    } state_e;

    function automatic logic [CTRL_W-1:0] lock_mask(input int idx);
        return (idx == 0 ? 32'h3 : 32'h1) << (8 * idx);
    endfunction

    function automatic logic [CTRL_W-1:0] slip_mask(input int idx);
        return 32'h1 << (8 * idx + 2);
    endfunction
endpackage

// File: rtl/pll_seq_rate.sv
module pll_seq_rate
    import pll_seq_pkg::*;
#(
    parameter int RATE_W = 32,
    localparam int OUT_W = RATE_W + 6
) (
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic [RATE_W-1:0] rate_in,
    output logic [OUT_W-1:0]  rate_out
);
    logic [6:0]       f_dec;
    logic [4:0]       r_dec, od_dec;
    logic [OUT_W-1:0] num, den;
    logic             unused_bits;

    assign unused_bits = ^{ctrl_word[CTRL_W-1:B_PWR+1], ctrl_word[B_RST:BW_LSB]};

    always_comb begin
        f_dec  = {1'b0, ctrl_word[F_LSB +: F_W]} + 7'd1;
        r_dec  = {1'b0, ctrl_word[R_LSB +: R_W]} + 5'd1;
        od_dec = {1'b0, ctrl_word[OD_LSB +: OD_W]} + 5'd1;
        num    = OUT_W'(rate_in) * OUT_W'(f_dec);
        den    = OUT_W'(10'(r_dec) * 10'(od_dec));
        if (ctrl_word[B_BYP])
            rate_out = OUT_W'(rate_in);
        else if (!ctrl_word[B_PWR])
            rate_out = '0;
        else
            rate_out = num / den;
    end
endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
    import pll_seq_pkg::*;
#(
    parameter int NUM_PLL  = 3,
    parameter int SEL_W    = 2,
    parameter int TMO_W    = 16,
    parameter int RST_HOLD = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cmd_valid,
    output logic                           cmd_ready,
    input  logic [1:0]                     cmd_op,
    input  logic [SEL_W-1:0]               cmd_sel,
    input  logic [4:0]                     cmd_r,
    input  logic [6:0]                     cmd_f,
    input  logic [4:0]                     cmd_od,
    input  logic [CTRL_W-1:0]              lock_status,
    input  logic [TMO_W-1:0]               lock_limit,
    input  logic [NUM_PLL-1:0][CTRL_W-1:0] ctrl_cur,
    output logic                           wr_en,
    output logic [SEL_W-1:0]               wr_idx,
    output logic [CTRL_W-1:0]              wr_val,
    output logic [CTRL_W-1:0]              clr_slip,
    output logic                           busy,
    output logic                           err
);
    state_e            state_q, state_d;
    op_e               op_q;
    logic [SEL_W-1:0]  sel_q;
    logic [R_W-1:0]    r_q;
    logic [F_W-1:0]    f_q;
    logic [OD_W-1:0]   od_q;
    logic [TMO_W-1:0]  cnt_q;
    logic              err_q;
    logic              sel_ok, already_on, accept, locked;
    logic [CTRL_W-1:0] cmd_word, cur, mask;

    always_comb begin
        sel_ok     = int'(cmd_sel) < NUM_PLL;
        cmd_word   = sel_ok ? ctrl_cur[cmd_sel] : '0;
        already_on = cmd_word[B_PWR] & cmd_word[B_EN] & ~cmd_word[B_RST];
        accept     = cmd_valid && (state_q == S_IDLE);
        cur        = ctrl_cur[sel_q];
        mask       = lock_mask(int'(sel_q));
        locked     = (lock_status & mask) == mask;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (cmd_valid && sel_ok) begin
                unique case (op_e'(cmd_op))
                    OP_ENABLE:  state_d = already_on ? S_IDLE : S_EN_PWR;
                    OP_DISABLE: state_d = S_DIS_BYP;
                    OP_REPROG:  state_d = S_DIS_BYP;
                    default:    state_d = S_IDLE;
                endcase
            end
            S_DIS_BYP:   state_d = S_DIS_OFF;
            S_DIS_OFF:   state_d = (op_q == OP_REPROG) ? S_PROG : S_IDLE;
            S_PROG:      state_d = S_EN_PWR;
            S_EN_PWR:    state_d = S_RST_LO;
            S_RST_LO:    state_d = S_RST_HI;
            S_RST_HI:    if (cnt_q == TMO_W'(RST_HOLD - 1)) state_d = S_RST_REL;
            S_RST_REL:   state_d = S_LOCK_WAIT;
            S_LOCK_WAIT: if (locked) state_d = S_EN_RUN;
                         else if (cnt_q == lock_limit) state_d = S_ERR_BYP;
            S_EN_RUN:    state_d = S_IDLE;
            S_ERR_BYP:   state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            op_q    <= OP_NONE;
            sel_q   <= '0;
            r_q     <= '0;
            f_q     <= '0;
            od_q    <= '0;
            cnt_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_d != state_q) ? '0 : cnt_q + 1'b1;
            if (accept) begin
                err_q <= 1'b0;
                if (sel_ok) begin
                    op_q  <= op_e'(cmd_op);
                    sel_q <= cmd_sel;
                    r_q   <= R_W'(cmd_r - 5'd1);
                    f_q   <= F_W'(cmd_f - 7'd1);
                    od_q  <= OD_W'(cmd_od - 5'd1);
                end
            end
            if (state_q == S_ERR_BYP)
                err_q <= 1'b1;
        end
    end

    always_comb begin
        wr_en    = 1'b0;
        wr_idx   = sel_q;
        wr_val   = cur;
        clr_slip = '0;
        unique case (state_q)
            S_DIS_BYP: begin wr_en = 1'b1; wr_val[B_BYP] = 1'b1; end
            S_DIS_OFF: begin
                wr_en = 1'b1; wr_val[B_PWR] = 1'b0; wr_val[B_EN] = 1'b0;
            end
            S_PROG: begin
                wr_en = 1'b1;
                wr_val[R_LSB +: R_W]   = r_q;
                wr_val[F_LSB +: F_W]   = f_q;
                wr_val[OD_LSB +: OD_W] = od_q;
                wr_val[BW_LSB +: BW_W] = f_q;
            end
            S_EN_PWR:    begin wr_en = 1'b1; wr_val[B_PWR] = 1'b1; end
            S_RST_LO:    begin wr_en = 1'b1; wr_val[B_RST] = 1'b0; end
            S_RST_HI:    begin wr_en = 1'b1; wr_val[B_RST] = 1'b1; end
            S_RST_REL:   begin wr_en = 1'b1; wr_val[B_RST] = 1'b0; end
            S_LOCK_WAIT: if (!locked) clr_slip = slip_mask(int'(sel_q));
            S_EN_RUN: begin
                wr_en = 1'b1; wr_val[B_BYP] = 1'b0; wr_val[B_EN] = 1'b1;
            end
            S_ERR_BYP:   begin wr_en = 1'b1; wr_val[B_BYP] = 1'b1; end
            default: ;
        endcase
        busy      = state_q != S_IDLE;
        cmd_ready = state_q == S_IDLE;
        err       = err_q;
    end
endmodule

// File: rtl/pll_seq.sv
module pll_seq
    import pll_seq_pkg::*;
#(
    parameter int NUM_PLL  = 3,
    parameter int RATE_W   = 32,
    parameter int TMO_W    = 16,
    parameter int RST_HOLD = 2,
    localparam int SEL_W   = (NUM_PLL > 1) ? $clog2(NUM_PLL) : 1,
    localparam int OUT_W   = RATE_W + 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_valid,
    output logic                       cmd_ready,
    input  logic [1:0]                 cmd_op,
    input  logic [SEL_W-1:0]           cmd_sel,
    input  logic [4:0]                 cmd_r,
    input  logic [6:0]                 cmd_f,
    input  logic [4:0]                 cmd_od,
    input  logic [31:0]                lock_status,
    input  logic [TMO_W-1:0]           lock_limit,
    input  logic [RATE_W-1:0]          rate_in,
    output logic [31:0]                clr_slip,
    output logic [NUM_PLL*32-1:0]      ctrl_regs,
    output logic [NUM_PLL*OUT_W-1:0]   rate_out,
    output logic                       busy,
    output logic                       err
);
    logic [NUM_PLL-1:0][CTRL_W-1:0] ctrl_q;
    logic                           wr_en;
    logic [SEL_W-1:0]               wr_idx;
    logic [CTRL_W-1:0]              wr_val;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            for (int i = 0; i < NUM_PLL; i++)
                if (wr_en && int'(wr_idx) == i)
                    ctrl_q[i] <= wr_val;
        end
    end

    assign ctrl_regs = ctrl_q;

    pll_seq_fsm #(
        .NUM_PLL(NUM_PLL), .SEL_W(SEL_W), .TMO_W(TMO_W), .RST_HOLD(RST_HOLD)
    ) fsm_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_sel(cmd_sel), .cmd_r(cmd_r), .cmd_f(cmd_f), .cmd_od(cmd_od),
        .lock_status(lock_status), .lock_limit(lock_limit), .ctrl_cur(ctrl_q),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
        .clr_slip(clr_slip), .busy(busy), .err(err)
    );

    for (genvar g = 0; g < NUM_PLL; g++) begin : g_rate
        pll_seq_rate #(.RATE_W(RATE_W)) rate_i (
            .ctrl_word(ctrl_q[g]),
            .rate_in(rate_in),
            .rate_out(rate_out[g*OUT_W +: OUT_W])
        );
    end
endmodule

// File: rtl/pll_seq_chk.sv
module pll_seq_chk
    import pll_seq_pkg::*;
#(
    parameter int NUM_PLL = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cmd_valid,
    input logic                  cmd_ready,
    input logic [31:0]           lock_status,
    input logic [31:0]           clr_slip,
    input logic [NUM_PLL*32-1:0] ctrl_regs,
    input logic                  busy,
    input logic                  err
);
    logic [NUM_PLL-1:0][31:0] w;
    assign w = ctrl_regs;

    assert_ready_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$past(busy)) |-> $past(cmd_valid && cmd_ready))
        else $error("busy rose without an accepted command");

    assert_slip_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_slip) && ((clr_slip != 0) -> busy))
        else $error("clear-slip not a single pulse inside a sequence");

    assert_err_after_seq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(busy))
        else $error("error raised outside a sequence");

    for (genvar i = 0; i < NUM_PLL; i++) begin : g_pll
        assert_rst_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(w[i][B_RST]) |-> $past(w[i][B_RST], 2))
            else $error("reset pulse shorter than two cycles");

        assert_bypass_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(w[i][B_PWR]) |-> (w[i][B_BYP] && $past(w[i][B_BYP])))
            else $error("power removed before bypass");

        assert_enable_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(w[i][B_EN]) |->
                (!w[i][B_BYP] && $past((lock_status & lock_mask(i)) == lock_mask(i))))
            else $error("output enabled without lock or with bypass");
    end
endmodule

bind pll_seq pll_seq_chk #(.NUM_PLL(NUM_PLL)) chk_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .lock_status(lock_status), .clr_slip(clr_slip), .ctrl_regs(ctrl_regs),
    .busy(busy), .err(err)
);

// File: tb/pll_seq_tb_top.sv
module pll_seq_tb_top;
    localparam int NUM_PLL = 3;
    localparam int RATE_W  = 16;
    localparam int TMO_W   = 8;
    localparam int OUT_W   = RATE_W + 6;
    localparam int PWR = 21, BYP = 23, EN = 25;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     cmd_valid = 1'b0;
    logic                     cmd_ready;
    logic [1:0]               cmd_op = 2'd3;
    logic [1:0]               cmd_sel = 2'd0;
    logic [4:0]               cmd_r = 5'd1;
    logic [6:0]               cmd_f = 7'd1;
    logic [4:0]               cmd_od = 5'd1;
    logic [31:0]              lock_status;
    logic [TMO_W-1:0]         lock_limit = 8'd200;
    logic [RATE_W-1:0]        rate_in = 16'd1000;
    logic [31:0]              clr_slip;
    logic [NUM_PLL*32-1:0]    ctrl_regs;
    logic [NUM_PLL*OUT_W-1:0] rate_out;
    logic                     busy, err;

    int checks = 0, errors = 0;
    int slips = 0, stray = 0, base_slips = 0, need = 0, cur_sel = 0, rdy_bad = 0;

    always #5 clk = ~clk;

    pll_seq #(.NUM_PLL(NUM_PLL), .RATE_W(RATE_W), .TMO_W(TMO_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_sel(cmd_sel), .cmd_r(cmd_r), .cmd_f(cmd_f),
        .cmd_od(cmd_od), .lock_status(lock_status), .lock_limit(lock_limit),
        .rate_in(rate_in), .clr_slip(clr_slip), .ctrl_regs(ctrl_regs),
        .rate_out(rate_out), .busy(busy), .err(err)
    );

    function automatic logic [31:0] lmask(int s);
        case (s)
            0: return 32'h0000_0003;
            1: return 32'h0000_0100;
            2: return 32'h0001_0000;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] smask(int s);
        case (s)
            0: return 32'h0000_0004;
            1: return 32'h0000_0400;
            2: return 32'h0004_0000;
            default: return 32'h0;
        endcase
    endfunction

    function automatic longint fields(int r, int f, int od);
        return longint'((r - 1) | ((f - 1) << 4) | ((od - 1) << 10) | ((f - 1) << 14));
    endfunction

    assign lock_status = (slips - base_slips >= need) ? lmask(cur_sel) : 32'h0;

    always @(posedge clk) begin
        if ((clr_slip & smask(cur_sel)) != 0) slips <= slips + 1;
        if ((clr_slip & ~smask(cur_sel)) != 0) stray <= stray + 1;
    end

    function automatic longint word(int s);
        return longint'(ctrl_regs[s*32 +: 32]);
    endfunction

    function automatic longint rate(int s);
        return longint'(rate_out[s*OUT_W +: OUT_W]);
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic issue(input int op, input int sel, input int r, input int f,
                         input int od, input int nd, output int cyc, output int sl);
        cur_sel    = sel;
        need       = nd;
        base_slips = slips;
        cmd_op     = 2'(op);
        cmd_sel    = 2'(sel);
        cmd_r      = 5'(r);
        cmd_f      = 7'(f);
        cmd_od     = 5'(od);
        if (!cmd_ready) rdy_bad++;
        cmd_valid  = 1'b1;
        @(negedge clk);
        cmd_valid  = 1'b0;
        cyc = 0;
        while (busy) begin
            if (cmd_ready) rdy_bad++;
            cyc++;
            @(negedge clk);
        end
        sl = slips - base_slips;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int cyc, sl;
        longint w1, w0, w2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(ctrl_regs == '0, "R1 ctrl", longint'(ctrl_regs[31:0]), 0);
        check(!busy && cmd_ready && !err && clr_slip == 0, "R1 flags",
              longint'({busy, cmd_ready, err}), 2);
        check(rate_out == '0, "R1 rate", longint'(rate_out[OUT_W-1:0]), 0);

        // R2 R7 R8 R5 sweep over every r/od pair
        for (int r = 1; r <= 16; r++) begin
            for (int od = 1; od <= 16; od++) begin
                int f, s, nd;
                longint exp_rate;
                f  = ((r * 7 + od * 3) % 64) + 1;
                s  = (r + od) % 3;
                nd = (r + od) % 4;
                rate_in = 16'(1000 + r * od * 97);
                issue(2, s, r, f, od, nd, cyc, sl);
                check(cyc == 10 + nd, "R7 reprogram busy cycles", cyc, 10 + nd);
                check(sl == nd, "R5 slip pulses", sl, nd);
                check(word(s) == (fields(r, f, od) | (1 << PWR) | (1 << EN)),
                      "R2 R7 control word", word(s),
                      fields(r, f, od) | (1 << PWR) | (1 << EN));
                exp_rate = longint'(rate_in) * f / (r * od);
                check(rate(s) == exp_rate, "R8 rate", rate(s), exp_rate);
            end
        end
        check(stray == 0, "R5 stray slip bits", stray, 0);

        // R9 timeout
        lock_limit = 8'd5;
        rate_in = 16'd4321;
        issue(2, 1, 3, 10, 2, 1000, cyc, sl);
        check(cyc == 15, "R9 timeout busy cycles", cyc, 15);
        check(sl == 6, "R9 slips before timeout", sl, 6);
        check(err == 1'b1, "R9 err", longint'(err), 1);
        check(word(1) == (fields(3, 10, 2) | (1 << PWR) | (1 << BYP)),
              "R9 left bypassed", word(1), fields(3, 10, 2) | (1 << PWR) | (1 << BYP));
        check(rate(1) == 4321, "R8 bypass rate", rate(1), 4321);
        lock_limit = 8'd200;

        // R6 disable, R10 err clear
        issue(1, 1, 1, 1, 1, 0, cyc, sl);
        check(cyc == 2, "R6 disable busy cycles", cyc, 2);
        check(err == 1'b0, "R10 err cleared", longint'(err), 0);
        check(word(1) == (fields(3, 10, 2) | (1 << BYP)), "R6 disabled word",
              word(1), fields(3, 10, 2) | (1 << BYP));
        check(rate(1) == 4321, "R8 rate after disable", rate(1), 4321);

        // R4 enable from disabled
        issue(0, 1, 1, 1, 1, 3, cyc, sl);
        check(cyc == 10, "R4 enable busy cycles", cyc, 10);
        check(sl == 3, "R5 enable slips", sl, 3);
        check(word(1) == (fields(3, 10, 2) | (1 << PWR) | (1 << EN)), "R4 enabled word",
              word(1), fields(3, 10, 2) | (1 << PWR) | (1 << EN));
        check(rate(1) == 4321 * 10 / 6, "R8 rate after enable", rate(1), 4321 * 10 / 6);

        // R3 enable on an enabled PLL
        w1 = word(1);
        issue(0, 1, 1, 1, 1, 0, cyc, sl);
        check(cyc == 0, "R3 no-op busy", cyc, 0);
        check(word(1) == w1, "R3 no-op word", word(1), w1);

        // R11 ignored commands
        w0 = word(0); w1 = word(1); w2 = word(2);
        issue(3, 0, 2, 2, 2, 0, cyc, sl);
        check(cyc == 0 && word(0) == w0, "R11 op none", word(0), w0);
        issue(2, 3, 2, 2, 2, 0, cyc, sl);
        check(cyc == 0, "R11 bad index busy", cyc, 0);
        check(word(0) == w0 && word(1) == w1 && word(2) == w2, "R11 bad index words",
              word(2), w2);
        check(rdy_bad == 0, "R10 ready while busy", rdy_bad, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule